// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register memory transfer into a stream of word addresses. A transfer is started with a base address, a register-selection mask, an ordering mode and a writeback request. The block then emits one word address and one register number per clock until every selected register has been served. It also computes the value the base register takes after the transfer.

The ordering can be given directly as one of four modes. Two of them step upward, starting at the base or one word above it. The other two place the block below the base, ending at the base or one word under it. The ordering can also be given as a stack discipline: full or empty, growing up or down. In that case the block turns the discipline into one of the four modes. The choice depends on whether the transfer is a load or a store, so that a load popping a stack undoes a store that pushed onto it. Whatever the direction, the lowest-numbered register always gets the lowest address, and addresses rise by 4 bytes per transfer.

Top module: `block_xfer_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `xfer_valid`, `done` and `wb_valid` are low and `wb_value` is zero.
- R2: Direct mode code 2'b00 (step up, address then move): the first transfer uses `base_addr`, and each following transfer uses the previous address plus 4, modulo 2^ADDR_W.
- R3: Direct mode code 2'b01 (step up, move then address): the first transfer uses `base_addr`+4, and later transfers step by +4.
- R4: Direct mode codes 2'b10 (step down, address then move) and 2'b11 (step down, move then address) place N transfers below the base, where N is the number of set bits in `reg_list`. The first address is `base_addr`−4N+4 for 2'b10 and `base_addr`−4N for 2'b11, and the addresses still rise by 4 per transfer.
- R5: Transfers start on the cycle after `start` is accepted and come one per cycle. Each one carries the index of a set bit of `reg_list` in ascending order, so every set bit appears exactly once.
- R6: `done` is high for exactly one cycle, the cycle of the final transfer.
- R7: `wb_value` is `base_addr`+4N for the upward codes and `base_addr`−4N for the downward codes. `wb_valid` is high together with `done` only when `wb_en` was high at start.
- R8: An all-zero `reg_list` produces no transfer. `done` pulses on the next cycle, and `wb_value` equals `base_addr`.
- R9: With `stack_sel`=1 and `is_load`=0, `mode` names a stack: 2'b00 full-down, 2'b01 empty-down, 2'b10 full-up, 2'b11 empty-up. For a store these give the direct codes 2'b11, 2'b10, 2'b01 and 2'b00.
- R10: With `stack_sel`=1 and `is_load`=1, the same stack names give the direct codes 2'b00, 2'b01, 2'b10 and 2'b11. A load that uses the store's `wb_value` as its base then touches each register at the address the store used, and restores the original base.
- R11: `start` is ignored while `busy` is high, including the cycle of an empty-list `done`. An ongoing transfer sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when not busy |
| base_addr | input | ADDR_W | Base register value |
| reg_list | input | NREGS | Register selection mask, bit i selects register i |
| mode | input | 2 | Direct ordering code, or stack name when `stack_sel` is high |
| stack_sel | input | 1 | Interpret `mode` as a stack name |
| is_load | input | 1 | Transfer is a load (affects stack-name translation) |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Sequence in progress; start is ignored |
| xfer_valid | output | 1 | A transfer is issued this cycle |
| xfer_addr | output | ADDR_W | Word address of the current transfer |
| xfer_reg | output | $clog2(NREGS) | Register index of the current transfer |
| done | output | 1 | Final transfer, or empty-list completion |
| wb_value | output | ADDR_W | Updated base value |
| wb_valid | output | 1 | Writeback strobe, with `done` |

## Verification
The bench builds the sequencer with an 8-entry register mask and a 16-bit address. With these values it can sweep all 256 masks under each of the four direct codes, with and without writeback. It also sweeps every mask under each stack name as a store followed by the matching load. The short address width lets the bases wrap below zero and above the top, so the modular address arithmetic is exercised, including for the downward modes.

// File: rtl/btas_pkg.sv
package btas_pkg;

    // Direct ordering codes: bit1 = step downward, bit0 = move before address
    typedef enum logic [1:0] {
        ORD_UP_POST   = 2'b00,
        ORD_UP_PRE    = 2'b01,
        ORD_DOWN_POST = 2'b10,
        ORD_DOWN_PRE  = 2'b11
    } order_e;

    // Stack names: bit1 = grows upward, bit0 = pointer at free slot
    typedef enum logic [1:0] {
        STK_FULL_DOWN  = 2'b00,
        STK_EMPTY_DOWN = 2'b01,
        STK_FULL_UP    = 2'b10,
        STK_EMPTY_UP   = 2'b11
    } stack_e;

    typedef struct packed {
        logic down;
        logic pre;
    } order_dec_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    // A store pushes: a full stack moves before writing, an empty one after.
    // A load pops in the opposite direction with the opposite timing.
    function automatic order_e stack_to_order(input stack_e stk, input logic load);
        logic grows_up;
        logic empty_kind;
        logic down;
        logic pre;
        grows_up   = stk[1];
        empty_kind = stk[0];
        if (!load) begin
            down = !grows_up;
            pre  = !empty_kind;
        end else begin
            down = grows_up;
            pre  = empty_kind;
        end
        return order_e'({down, pre});
    endfunction

    function automatic order_dec_t decode_order(input order_e ord);
        order_dec_t d;
        d.down = ord[1];
        d.pre  = ord[0];
        return d;
    endfunction

endpackage

// File: rtl/btas_mode_xlate.sv
module btas_mode_xlate
    import btas_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic        stack_sel,
    input  logic        is_load,
    output order_dec_t  dec
);
    order_e eff;

    always_comb begin
        if (stack_sel) eff = stack_to_order(stack_e'(mode), is_load);
        else           eff = order_e'(mode);
        dec = decode_order(eff);
    end
endmodule

// File: rtl/btas_addr_plan.sv
module btas_addr_plan
    import btas_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREGS  = 16
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREGS-1:0]  reg_list,
    input  order_dec_t        dec,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] final_base
);
    localparam int CNT_W = $clog2(NREGS + 1);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low_end;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREGS; i++) begin
            count = count + CNT_W'(reg_list[i]);
        end
    end

    assign span    = ADDR_W'(count) << 2;
    assign low_end = base_addr - span;

    always_comb begin
        unique case ({dec.down, dec.pre})
            2'b00:   first_addr = base_addr;
            2'b01:   first_addr = base_addr + WORD;
            2'b10:   first_addr = low_end + WORD;
            default: first_addr = low_end;
        endcase
        final_base = dec.down ? low_end : base_addr + span;
    end
endmodule

// File: rtl/btas_pick_lowest.sv
module btas_pick_lowest #(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [NREGS-1:0] mask,
    output logic [NREGS-1:0] lowest_oh,
    output logic [IDX_W-1:0] lowest_idx,
    output logic             only_one
);
    logic [NREGS-1:0] seen_below;

    assign seen_below[0] = 1'b0;
    assign lowest_oh[0]  = mask[0];

    genvar g;
    generate
        for (g = 1; g < NREGS; g++) begin : g_chain
            assign seen_below[g] = seen_below[g-1] | mask[g-1];
            assign lowest_oh[g]  = mask[g] & ~seen_below[g];
        end
    endgenerate

    always_comb begin
        lowest_idx = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (lowest_oh[i]) lowest_idx = lowest_idx | IDX_W'(i);
        end
    end

    assign only_one = (|mask) && ((mask & ~lowest_oh) == '0);
endmodule

// File: rtl/block_xfer_seq.sv
module block_xfer_seq
    import btas_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREGS-1:0]  reg_list,
    input  logic [1:0]        mode,
    input  logic              stack_sel,
    input  logic              is_load,
    input  logic              wb_en,
    output logic              busy,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [IDX_W-1:0]  xfer_reg,
    output logic              done,
    output logic [ADDR_W-1:0] wb_value,
    output logic              wb_valid
);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    order_dec_t        dec;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_final;

    seq_state_e        state_q;
    logic [NREGS-1:0]  pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbv_q;
    logic              wben_q;
    logic              empty_done_q;

    logic [NREGS-1:0]  low_oh;
    logic [IDX_W-1:0]  low_idx;
    logic              last_one;
    logic              accept;
    logic              running;

    btas_mode_xlate u_xlate (
        .mode      (mode),
        .stack_sel (stack_sel),
        .is_load   (is_load),
        .dec       (dec)
    );

    btas_addr_plan #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_plan (
        .base_addr  (base_addr),
        .reg_list   (reg_list),
        .dec        (dec),
        .first_addr (plan_first),
        .final_base (plan_final)
    );

    btas_pick_lowest #(.NREGS(NREGS)) u_pick (
        .mask       (pend_q),
        .lowest_oh  (low_oh),
        .lowest_idx (low_idx),
        .only_one   (last_one)
    );

    assign running = (state_q == SQ_RUN);
    assign busy    = running || empty_done_q;
    assign accept  = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SQ_IDLE;
            pend_q       <= '0;
            addr_q       <= '0;
            wbv_q        <= '0;
            wben_q       <= 1'b0;
            empty_done_q <= 1'b0;
        end else begin
            empty_done_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        pend_q <= reg_list;
                        addr_q <= plan_first;
                        wbv_q  <= plan_final;
                        wben_q <= wb_en;
                        if (reg_list == '0) empty_done_q <= 1'b1;
                        else                state_q      <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    pend_q <= pend_q & ~low_oh;
                    addr_q <= addr_q + WORD;
                    if (last_one) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign xfer_valid = running;
    assign xfer_addr  = addr_q;
    assign xfer_reg   = low_idx;
    assign done       = (running && last_one) || empty_done_q;
    assign wb_value   = wbv_q;
    assign wb_valid   = done && wben_q;

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !done) |=> (xfer_valid && xfer_addr == $past(xfer_addr) + WORD));

    // R5
    reg_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !done) |=> (xfer_reg > $past(xfer_reg)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !xfer_valid));

    // R7
    wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

    // R8
    start_response_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (xfer_valid || done));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> ($stable(wb_value) && busy));
endmodule

// File: tb/block_xfer_seq_tb_top.sv
module block_xfer_seq_tb_top;
    localparam int AW = 16;
    localparam int NR = 8;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] base_addr;
    logic [NR-1:0] reg_list;
    logic [1:0]    mode;
    logic          stack_sel;
    logic          is_load;
    logic          wb_en;
    logic          busy;
    logic          xfer_valid;
    logic [AW-1:0] xfer_addr;
    logic [IW-1:0] xfer_reg;
    logic          done;
    logic [AW-1:0] wb_value;
    logic          wb_valid;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [AW-1:0] seen_addr [NR];
    logic [AW-1:0] seen_wb;

    always #2.5 clk = ~clk;

    block_xfer_seq #(.ADDR_W(AW), .NREGS(NR)) dut_i (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .reg_list(reg_list), .mode(mode), .stack_sel(stack_sel),
        .is_load(is_load), .wb_en(wb_en), .busy(busy),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
        .done(done), .wb_value(wb_value), .wb_valid(wb_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Effective direct code from the requirement tables (R9, R10)
    function automatic logic [1:0] eff_code(input logic [1:0] m, input bit stk, input bit ld);
        if (!stk) return m;
        if (!ld) begin
            case (m)
                2'b00: return 2'b11;
                2'b01: return 2'b10;
                2'b10: return 2'b01;
                default: return 2'b00;
            endcase
        end
        return m;
    endfunction

    task automatic run_op(input logic [AW-1:0] b, input logic [NR-1:0] lst,
                          input logic [1:0] m, input bit stk, input bit ld,
                          input bit wb, input bit poke);
        int n;
        int k;
        logic [1:0]    ec;
        logic [AW-1:0] first;
        logic [AW-1:0] fin;
        logic [AW-1:0] span;
        n = $countones(lst);
        span = AW'(n * 4);
        ec = eff_code(m, stk, ld);
        case (ec)
            2'b00: first = b;
            2'b01: first = b + 16'd4;
            2'b10: first = b - span + 16'd4;
            default: first = b - span;
        endcase
        fin = ec[1] ? b - span : b + span;
        base_addr = b; reg_list = lst; mode = m; stack_sel = stk;
        is_load = ld; wb_en = wb; start = 1'b1;
        @(negedge clk);
        if (poke) begin
            base_addr = ~b; reg_list = ~lst; mode = ~m; wb_en = ~wb;
        end else begin
            start = 1'b0;
        end
        if (n == 0) begin
            chk(done && !xfer_valid, "R8 empty done", {done, xfer_valid}, 2'b10);
            chk(wb_value == b, "R8 base kept", wb_value, b);
            chk(wb_valid == wb, "R7 wb strobe", wb_valid, wb);
            seen_wb = wb_value;
            start = 1'b0;
            @(negedge clk);
            chk(!done && !busy, "R8 idle after", {done, busy}, 2'b00);
            return;
        end
        k = 0;
        for (int r = 0; r < NR; r++) begin
            if (lst[r]) begin
                chk(xfer_valid, "R5 valid", xfer_valid, 1);
                chk(xfer_reg == IW'(r), "R5 reg order", xfer_reg, r);
                chk(xfer_addr == first + AW'(4 * k),
                    ec == 2'b00 ? "R2 addr" : ec == 2'b01 ? "R3 addr" : "R4 addr",
                    xfer_addr, first + AW'(4 * k));
                chk(done == (k == n - 1), "R6 done", done, k == n - 1);
                if (poke) chk(busy, "R11 busy held", busy, 1);
                seen_addr[r] = xfer_addr;
                if (k == n - 1) begin
                    chk(wb_value == fin, "R7 wb value", wb_value, fin);
                    chk(wb_valid == wb, "R7 wb strobe", wb_valid, wb);
                    seen_wb = wb_value;
                    start = 1'b0;
                end
                k++;
                @(negedge clk);
            end
        end
        chk(!xfer_valid && !done && !busy, "R6 end", {xfer_valid, done, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] orig [NR];
        logic [AW-1:0] b0;
        rst = 1'b1; start = 1'b0; base_addr = '0; reg_list = '0; mode = '0;
        stack_sel = 1'b0; is_load = 1'b0; wb_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !xfer_valid && !done && !wb_valid && wb_value == 0,
            "R1 reset", {busy, xfer_valid, done, wb_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Direct codes, every mask, with and without writeback
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 256; l++) begin
                run_op(AW'(l * 52 + m * 7 + 16'hFFC0), NR'(l), 2'(m), 1'b0, 1'b0,
                       l[0], 1'b0);
            end
        end

        // Start pokes while busy, including an empty list
        run_op(16'h1234, 8'hA5, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op(16'h0008, 8'hFF, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op(16'h4000, 8'h00, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);

        // Stack names: store then the matching load restores (R9, R10)
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 256; l++) begin
                b0 = AW'(l * 36 + s * 12 + 16'hFFF0);
                run_op(b0, NR'(l), 2'(s), 1'b1, 1'b0, 1'b1, 1'b0);
                for (int r = 0; r < NR; r++) orig[r] = seen_addr[r];
                run_op(seen_wb, NR'(l), 2'(s), 1'b1, 1'b1, 1'b1, 1'b0);
                for (int r = 0; r < NR; r++) begin
                    if (l[r]) chk(seen_addr[r] == orig[r], "R10 same slot", seen_addr[r], orig[r]);
                end
                chk(seen_wb == b0, "R10 base restored", seen_wb, b0);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule